// File: doc/BRIEF.md
# Two-Phase Signature Self-Test Controller

This block wraps a streaming datapath for a built-in self test. When the host writes the start bit, the block stops passing the functional input to the datapath. It drives a pseudo-noise word instead and compresses every valid word seen on the datapath's output tap into a 16-bit signature. A phase ends by itself once a fixed number of valid output samples has been taken. The start bit then reads back as zero.

A complete test has two phases, and the host resets the datapath channels before each one. The signature is cleared only when phase one starts, so phase two keeps folding into the same value. The host can load an expected value and read a match flag in the status register. It can also read the computed signature and compare it in software.

Top module: `bist_sig_ctrl`

## Requirements
- R1: After reset, control reads 0, the signature register reads 0, status reads 0, `in_sel_o` is 0 and `dp_data_o` equals `user_data_i`.
- R2: While no phase is running, `dp_data_o` follows `user_data_i` combinationally and `in_sel_o` is 0.
- R3: A write to address 0 with bit 0 set starts a phase. From the next cycle until the phase ends, `in_sel_o` is 1 and `dp_data_o` carries a 16-bit LFSR zero-extended to the data width. The LFSR starts at 16'hACE1 and steps once per cycle as next = {s[14:0], s[15]^s[13]^s[12]^s[10]}.
- R4: Control bit 0 reads 1 while a phase runs. It reads 0 from the edge at which the PHASE_LEN-th tap sample with `tap_valid_i` high is taken. Cycles with `tap_valid_i` low are not counted.
- R5: On every counted sample the signature becomes {m[14:0], m[15]^m[13]^m[12]^m[10]} XOR fold(tap). Here fold XORs tap bit i into bit i mod 16. The signature is cleared when phase one starts and is kept when phase two starts.
- R6: Address 1 returns the computed signature in bits 31:16 and the expected signature in bits 15:0. A write to address 1 loads only bits 15:0. Bits 31:16 of the write data are ignored.
- R7: Status (address 2) bit 12 is 1 exactly when both phases have completed and the computed signature equals the expected one. Status bit 4 is 1 when the next start will run phase two. Bit 12 clears when a new phase one starts.
- R8: A start write while a phase is running is ignored: the count, the LFSR and the signature carry on unchanged. A write of 0 to control starts nothing.
- R9: If the expected signature is written in the same cycle that phase two completes, both take effect, and bit 12 is judged against the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 control, 1 signature, 2 status |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| user_data_i | input | DATA_W | Functional input to the datapath |
| dp_data_o | output | DATA_W | Input word presented to the datapath |
| in_sel_o | output | 1 | 1 when the pseudo-noise word is selected |
| tap_data_i | input | DATA_W | Output tap of the datapath |
| tap_valid_i | input | 1 | Tap word is valid this cycle |

## Verification
Two functions can land on the same edge: completion of phase two, which sets the completion state and freezes the signature, and a host write of the expected signature. The bench predicts the final signature one cycle early. In the cycle that carries the last counted sample, it writes that predicted value as the expected signature. One cycle later it reads status and requires bit 12 to be 1, which shows that neither update was lost. Start writes issued in the middle of a phase are also checked, by watching that the LFSR stream and the signature continue without a restart.

// File: rtl/bist_pkg.sv
package bist_pkg;
  localparam int unsigned SIG_W = 16;
  localparam int unsigned STAT_MATCH_BIT = 12;
  localparam int unsigned STAT_PHASE_BIT = 4;

  typedef enum logic [1:0] {
    ADR_CTRL = 2'd0,
    ADR_SIG  = 2'd1,
    ADR_STAT = 2'd2,
    ADR_NONE = 2'd3
  } reg_addr_e;

  // shift with feedback x^16+x^14+x^13+x^11+1
  function automatic logic [SIG_W-1:0] shift_fb(input logic [SIG_W-1:0] s);
    return {s[SIG_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction
endpackage

// File: rtl/bist_pn_gen.sv
module bist_pn_gen
  import bist_pkg::*;
#(
  parameter int unsigned DATA_W = 24,
  parameter logic [SIG_W-1:0] SEED = 16'hACE1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              seed_i,
  input  logic              run_i,
  input  logic [DATA_W-1:0] user_data_i,
  output logic [DATA_W-1:0] dp_data_o
);
  logic [SIG_W-1:0]  lfsr_q;
  logic [DATA_W-1:0] pn_word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lfsr_q <= SEED;
    else if (seed_i) lfsr_q <= SEED;
    else if (run_i)  lfsr_q <= shift_fb(lfsr_q);
  end

  generate
    if (DATA_W <= SIG_W) begin : g_trunc
      assign pn_word = lfsr_q[DATA_W-1:0];
    end else begin : g_pad
      assign pn_word = {{(DATA_W-SIG_W){1'b0}}, lfsr_q};
    end
  endgenerate

  assign dp_data_o = run_i ? pn_word : user_data_i;

  AST_PN_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> lfsr_q != '0); // R3
  AST_PN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !seed_i) |=> lfsr_q == shift_fb($past(lfsr_q))); // R3
endmodule

// File: rtl/bist_misr.sv
module bist_misr
  import bist_pkg::*;
#(
  parameter int unsigned DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic [DATA_W-1:0] tap_i,
  output logic [SIG_W-1:0]  sig_o
);
  logic [SIG_W-1:0] folded;

  always_comb begin
    folded = '0;
    for (int i = 0; i < DATA_W; i++) folded[i % SIG_W] ^= tap_i[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sig_o <= '0;
    else if (clr_i) sig_o <= '0;
    else if (en_i)  sig_o <= shift_fb(sig_o) ^ folded;
  end

  AST_SIG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(sig_o)); // R5
  AST_SIG_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> sig_o == '0); // R5
endmodule

// File: rtl/bist_seq.sv
module bist_seq #(
  parameter int unsigned PHASE_LEN = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic valid_i,
  output logic busy_o,
  output logic seed_o,
  output logic clr_sig_o,
  output logic count_o,
  output logic phase2_o,
  output logic complete_o
);
  localparam int unsigned CNT_W = (PHASE_LEN > 2) ? $clog2(PHASE_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PHASE_LEN - 1);

  logic [CNT_W-1:0] cnt_q;
  logic busy_q, phase2_q, done_q, go;

  assign go         = start_i && !busy_q;
  assign seed_o     = go;
  assign clr_sig_o  = go && !phase2_q;
  assign count_o    = busy_q && valid_i;
  assign busy_o     = busy_q;
  assign phase2_o   = phase2_q;
  assign complete_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      cnt_q    <= '0;
      phase2_q <= 1'b0;
      done_q   <= 1'b0;
    end else if (go) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      if (!phase2_q) done_q <= 1'b0;
    end else if (count_o) begin
      if (cnt_q == LAST) begin
        busy_q   <= 1'b0;
        phase2_q <= ~phase2_q;
        if (phase2_q) done_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> cnt_q <= LAST); // R4
  AST_END_ON_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(valid_i)); // R4
  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !valid_i) |=> busy_q && $stable(cnt_q)); // R8
  AST_DONE_ONLY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !phase2_q); // R7
endmodule

// File: rtl/bist_sig_ctrl.sv
module bist_sig_ctrl
  import bist_pkg::*;
#(
  parameter int unsigned DATA_W    = 24,
  parameter int unsigned PHASE_LEN = 4096,
  parameter logic [15:0] SEED      = 16'hACE1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic [DATA_W-1:0] user_data_i,
  output logic [DATA_W-1:0] dp_data_o,
  output logic              in_sel_o,
  input  logic [DATA_W-1:0] tap_data_i,
  input  logic              tap_valid_i
);
  logic busy, seed, clr_sig, count, phase2, complete, start, match;
  logic [SIG_W-1:0] sig, exp_q;
  reg_addr_e addr;

  assign addr  = reg_addr_e'(reg_addr_i);
  assign start = reg_we_i && (addr == ADR_CTRL) && reg_wdata_i[0];

  bist_seq #(.PHASE_LEN(PHASE_LEN)) u_seq (
    .clk_i, .rst_ni, .start_i(start), .valid_i(tap_valid_i),
    .busy_o(busy), .seed_o(seed), .clr_sig_o(clr_sig), .count_o(count),
    .phase2_o(phase2), .complete_o(complete)
  );

  bist_pn_gen #(.DATA_W(DATA_W), .SEED(SEED)) u_pn (
    .clk_i, .rst_ni, .seed_i(seed), .run_i(busy),
    .user_data_i, .dp_data_o
  );

  bist_misr #(.DATA_W(DATA_W)) u_misr (
    .clk_i, .rst_ni, .clr_i(clr_sig), .en_i(count),
    .tap_i(tap_data_i), .sig_o(sig)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) exp_q <= '0;
    else if (reg_we_i && addr == ADR_SIG) exp_q <= reg_wdata_i[SIG_W-1:0];
  end

  assign match    = complete && (sig == exp_q);
  assign in_sel_o = busy;

  always_comb begin
    reg_rdata_o = '0;
    case (addr)
      ADR_CTRL: reg_rdata_o[0] = busy;
      ADR_SIG:  reg_rdata_o    = {sig, exp_q};
      ADR_STAT: begin
        reg_rdata_o[STAT_MATCH_BIT] = match;
        reg_rdata_o[STAT_PHASE_BIT] = phase2;
      end
      default:  reg_rdata_o = '0;
    endcase
  end

  AST_EXP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_i && addr == ADR_SIG) |=> $stable(exp_q)); // R6
  AST_SEL_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_sel_o |-> dp_data_o == user_data_i); // R2
endmodule

// File: tb/sim_bist_sig_ctrl.sv
module sim_bist_sig_ctrl;
  localparam int DW = 24;
  localparam int LEN = 16;

  logic clk = 0, rst_n = 0;
  logic we = 0;
  logic [1:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [DW-1:0] user = 0, dp, tap = 0;
  logic sel, tvalid = 0;
  int n_chk = 0, n_fail = 0;
  logic [15:0] m_lfsr, m_sig, m_exp;

  always #4 clk = ~clk;

  bist_sig_ctrl #(.DATA_W(DW), .PHASE_LEN(LEN)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .user_data_i(user),
    .dp_data_o(dp), .in_sel_o(sel), .tap_data_i(tap), .tap_valid_i(tvalid)
  );

  function automatic logic [15:0] fb(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction
  function automatic logic [15:0] fold(input logic [DW-1:0] d);
    logic [15:0] f = '0;
    for (int i = 0; i < DW; i++) f[i % 16] ^= d[i];
    return f;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] v);
    @(negedge clk); we = 1; addr = a; wdata = v;
    @(negedge clk); we = 0;
  endtask

  // mode: 0 every cycle, 1 every other, 2 irregular; retry: start write mid-run;
  // late_exp: write predicted signature in the completing cycle
  task automatic run_phase(input int mode, input bit first, input bit retry, input bit late_exp);
    logic [31:0] v;
    int k = 0, c = 0, bad_pn = 0;
    @(negedge clk); we = 1; addr = 0; wdata = 1;
    @(negedge clk); we = 0;
    m_lfsr = 16'hACE1;
    if (first) begin
      m_sig = 0;
      rd(1, v); chk("R5 sig cleared at phase one", {16'b0, v[31:16]}, 0);
      rd(2, v); chk("R7 match cleared at phase one", {31'b0, v[12]}, 0);
    end
    while (k < LEN) begin
      logic vld;
      logic [DW-1:0] d;
      rd(0, v);
      if (v[0] !== 1'b1 || dp !== {8'b0, m_lfsr} || sel !== 1'b1) bad_pn++;
      vld = (mode == 0) || (mode == 1 && c[0]) || (mode == 2 && (c * 7) % 3 != 0);
      d = DW'(c * 32'h9E3779 + 5);
      tvalid = vld; tap = d;
      we = 0;
      if (retry && c == 3) begin we = 1; addr = 0; wdata = 1; end
      if (late_exp && vld && k == LEN - 1) begin
        we = 1; addr = 1; wdata = {16'hFFFF, fb(m_sig) ^ fold(d)};
        m_exp = fb(m_sig) ^ fold(d);
      end
      @(negedge clk);
      we = 0;
      m_lfsr = fb(m_lfsr);
      if (vld) begin m_sig = fb(m_sig) ^ fold(d); k++; end
      c++;
    end
    tvalid = 0;
    chk(retry ? "R8 run unaffected by mid-run start" : "R3 PN stream", bad_pn, 0);
    user = DW'(c * 13 + 1);
    rd(0, v); chk("R4 start bit cleared at last sample", v, 0);
    chk("R2 passthrough after phase", {8'b0, dp}, {8'b0, user});
    rd(1, v); chk("R5 signature", {16'b0, v[31:16]}, {16'b0, m_sig});
  endtask

  initial begin
    #(8 * 20000);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    user = 24'h5A5A5A;
    #1;
    chk("R1 dp follows user in reset", {8'b0, dp}, {8'b0, user});
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(0, v); chk("R1 ctrl reset", v, 0);
    rd(1, v); chk("R1 sig reset", v, 0);
    rd(2, v); chk("R1 status reset", v, 0);
    chk("R1 in_sel reset", {31'b0, sel}, 0);

    for (int i = 0; i < 8; i++) begin
      user = DW'(i * 24'h123457 + 24'h800001);
      #1; chk("R2 idle passthrough", {8'b0, dp}, {8'b0, user});
    end

    wr(0, 0);
    rd(0, v); chk("R8 write of 0 starts nothing", v, 0);
    chk("R8 no PN after zero write", {31'b0, sel}, 0);

    wr(1, 32'hBEEF_1234);
    rd(1, v); chk("R6 expected loads low half only", v, 32'h0000_1234);

    run_phase(0, 1, 0, 0);
    rd(2, v); chk("R7 phase two pending", v, 32'h10);

    run_phase(1, 0, 1, 1);  // R9: expected written in completing cycle
    rd(2, v); chk("R9 match uses same-cycle expected", v, 32'h1000);
    rd(1, v); chk("R6 readback of expected", {16'b0, v[15:0]}, {16'b0, m_exp});

    wr(1, {16'h0, m_exp ^ 16'h0001});
    rd(2, v); chk("R7 mismatch clears bit 12", {31'b0, v[12]}, 0);
    wr(1, {16'h0, m_exp});
    rd(2, v); chk("R7 match restored", {31'b0, v[12]}, 1);

    wr(1, 0);
    run_phase(2, 1, 0, 0);
    run_phase(2, 0, 0, 0);
    rd(2, v); chk("R7 status after second test", v, (m_sig == 16'h0) ? 32'h1000 : 32'h0);
    wr(1, {16'h0, m_sig});
    rd(2, v); chk("R7 software-loaded match", v, 32'h1000);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule